// File: doc/BRIEF.md
# Keyed Randomized Set-Index Cache

This block is a small set-associative cache in which the set that holds a line is not taken from fixed address bits. Instead the whole line address is mixed with a secret key through a non-linear substitution hash, and a few bits folded out of the result select the set. An observer who does not know the key cannot predict which addresses collide in a set, and loading a new key moves every line to a different set. Because many addresses share a set under the hash, each tag entry stores the complete line address, so a hit is exact and an evicted line's address is known for write-back.

The processor side issues one read or write at a time through a ready/valid request port and gets a registered response carrying a hit flag and the read word. Misses go out through a line-wide refill port to the next level: a dirty victim is written back first, then the requested line is fetched and installed (write-allocate). A one-cycle key-load pulse installs a new key and starts a sweep that invalidates one set per cycle while the request port is held not-ready.

Top module: `keyed_rand_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req are 0, every line is invalid (the first access to any address misses), every round-robin pointer is 0 and the key is 0.
- R2: For way w the set index is computed from the 26-bit line address LA (byte address bits 31:6) and 32-bit key K: x = zero-extended LA XOR K (XOR w*0x9E3779B9 only when skewing is enabled, off by default); y = S(x); y2 = y XOR (y rotated left by 13); z = S(y2); index = XOR of the eight 4-bit nibbles of z. S replaces every nibble n by entry n of the table C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (hex).
- R3: A lookup hits only in a way whose entry at its own computed set is valid and whose stored 26-bit line address equals the request's; at most one way hits, and two resident lines sharing a set each return their own data.
- R4: A request taken at a rising edge with req_valid=1 and req_ready=1 gives, on a hit, resp_valid=1 and resp_hit=1 after the next rising edge; a read returns the 32-bit word selected by address bits 5:2, a write returns the written word.
- R5: On a miss the block raises mem_req with mem_write=0 and mem_addr equal to the request line address; at the edge where mem_ack is 1 it installs mem_rdata and registers resp_valid=1, resp_hit=0 and the requested word (word i of a line is bits 32*i+31:32*i).
- R6: When the victim entry is valid and dirty, the block first writes it back (mem_req=1, mem_write=1, mem_addr = stored line address, mem_wdata = stored line) and starts the refill only after that write is acknowledged; a clean or invalid victim causes no write.
- R7: The victim is the way named by the round-robin pointer of the set computed for way 0; each refill advances that pointer by one, wrapping from 3 to 0.
- R8: A key_load pulse while idle stores key_in and holds req_ready at 0 for exactly 16 cycles while the sets are invalidated (dirty data is dropped, pointers kept); afterwards every previously resident line misses and set indices use the new key.
- R9: A write hit replaces the addressed word and marks the line dirty; a write miss allocates the refilled line with the word replaced and marks it dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | One-cycle pulse, taken only while idle; has priority over a request in the same cycle |
| key_in | input | 32 | New key value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from a hit |
| resp_rdata | output | 32 | Read word, or the written word for writes |
| mem_req | output | 1 | Next-level transfer request |
| mem_write | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | 26 | Line address of the transfer |
| mem_wdata | output | 512 | Line written back |
| mem_ack | input | 1 | One-cycle acknowledge ending the transfer |
| mem_rdata | input | 512 | Refill line, valid with mem_ack |

## Verification
A hit answer is due exactly two rising edges after the request is presented (the hash register, then the response register), so the bench samples resp_valid on the falling edge after the first of those edges to see it still low and on the falling edge after the second to see the answer. A miss answer is due at the edge that takes the refill acknowledge, which the behavioural responder raises two cycles after it sees mem_req; the bench waits falling edge by falling edge for it and checks that the write-back count and contents seen in between match the reference model. After a key load the bench counts the falling edges on which req_ready is low and expects sixteen.

// File: rtl/krc_pkg.sv
package krc_pkg;

  localparam int HASH_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_SWEEP
  } krc_state_e;

  function automatic logic [3:0] sbox4(input logic [3:0] n);
    case (n)
      4'h0: return 4'hC;  4'h1: return 4'h5;  4'h2: return 4'h6;  4'h3: return 4'hB;
      4'h4: return 4'h9;  4'h5: return 4'h0;  4'h6: return 4'hA;  4'h7: return 4'hD;
      4'h8: return 4'h3;  4'h9: return 4'hE;  4'hA: return 4'hF;  4'hB: return 4'h8;
      4'hC: return 4'h4;  4'hD: return 4'h7;  4'hE: return 4'h1;  default: return 4'h2;
    endcase
  endfunction

  function automatic logic [HASH_W-1:0] subst(input logic [HASH_W-1:0] x);
    logic [HASH_W-1:0] o;
    for (int i = 0; i < HASH_W / 4; i++) o[4*i +: 4] = sbox4(x[4*i +: 4]);
    return o;
  endfunction

endpackage

// File: rtl/krc_hash.sv
module krc_hash
  import krc_pkg::*;
#(
  parameter int LA_W  = 26,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4,
  parameter bit SKEW  = 1'b0
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [LA_W-1:0]         la,
  input  logic [HASH_W-1:0]       key,
  output logic [WAYS*IDX_W-1:0]   idx_q
);

  localparam int CHUNKS = HASH_W / IDX_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [HASH_W-1:0] TWEAK =
      SKEW ? HASH_W'(w) * HASH_W'(32'h9E3779B9) : '0;
    logic [HASH_W-1:0] r1, r2;
    logic [IDX_W-1:0]  fold;

    always_comb begin
      r1 = subst(HASH_W'(la) ^ key ^ TWEAK);
      r2 = subst(r1 ^ {r1[HASH_W-14:0], r1[HASH_W-1:HASH_W-13]});
      fold = '0;
      for (int i = 0; i < CHUNKS; i++) fold = fold ^ r2[i*IDX_W +: IDX_W];
    end

    always_ff @(posedge clk) begin
      if (en) idx_q[w*IDX_W +: IDX_W] <= fold;
    end
  end

endmodule

// File: rtl/krc_way.sv
module krc_way #(
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_dirty,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_set,
  output logic              valid,
  output logic              dirty,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] line
);

  logic [SETS-1:0]   vbits, dbits;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      line_mem[wr_set] <= wr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits <= '0;
      dbits <= '0;
    end else begin
      if (inv_en) vbits[inv_set] <= 1'b0;
      if (wr_en) begin
        vbits[wr_set] <= 1'b1;
        dbits[wr_set] <= wr_dirty;
      end
    end
  end

  assign valid = vbits[rd_set];
  assign dirty = dbits[rd_set];
  assign tag   = tag_mem[rd_set];
  assign line  = line_mem[rd_set];

  // R8: a swept set is invalid on the following cycle
  assert_sweep_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !wr_en) |=> !vbits[$past(inv_set)])
    else $error("sweep left set valid");

endmodule

// File: rtl/keyed_rand_cache.sv
module keyed_rand_cache
  import krc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter bit SKEW       = 1'b0,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_load,
  input  logic [HASH_W-1:0] key_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_write,
  output logic [LA_W-1:0]   mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);

  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = OFF_W - BOFF_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WPTR_W = $clog2(WAYS);

  krc_state_e        state;
  logic [HASH_W-1:0] key_q;
  logic [LA_W-1:0]   la_q;
  logic [WOFF_W-1:0] woff_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic [WPTR_W-1:0] vic_q;
  logic [IDX_W-1:0]  sweep_cnt;
  logic [WPTR_W-1:0] rr [SETS];

  logic accept, rekey;
  assign rekey  = (state == ST_IDLE) && key_load;
  assign accept = (state == ST_IDLE) && req_valid && !key_load;

  logic unused_lo;
  assign unused_lo = ^req_addr[BOFF_W-1:0];

  // hash stage
  logic [WAYS*IDX_W-1:0] idx_flat;
  logic [IDX_W-1:0]      set_w [WAYS];

  krc_hash #(.LA_W(LA_W), .WAYS(WAYS), .IDX_W(IDX_W), .SKEW(SKEW)) u_hash (
    .clk(clk), .en(accept), .la(req_addr[ADDR_W-1:OFF_W]), .key(key_q), .idx_q(idx_flat)
  );

  // ways
  logic              w_valid [WAYS];
  logic              w_dirty [WAYS];
  logic [LA_W-1:0]   w_tag   [WAYS];
  logic [LINE_W-1:0] w_line  [WAYS];
  logic [WAYS-1:0]   hitvec, wen;
  logic [LINE_W-1:0] new_line;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign set_w[w]  = idx_flat[w*IDX_W +: IDX_W];
    assign hitvec[w] = w_valid[w] && (w_tag[w] == la_q);
    assign wen[w]    = ((state == ST_LOOK) && hitvec[w] && wr_q) ||
                       ((state == ST_FILL) && mem_ack && (vic_q == WPTR_W'(w)));
    krc_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(LA_W), .LINE_W(LINE_W)) u_way (
      .clk(clk), .rst(rst), .rd_set(set_w[w]),
      .wr_en(wen[w]), .wr_set(set_w[w]), .wr_tag(la_q), .wr_dirty(wr_q), .wr_line(new_line),
      .inv_en(state == ST_SWEEP), .inv_set(sweep_cnt),
      .valid(w_valid[w]), .dirty(w_dirty[w]), .tag(w_tag[w]), .line(w_line[w])
    );
  end

  logic              hit;
  logic [WPTR_W-1:0] hit_idx, victim;
  logic [LINE_W-1:0] base_line;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++) if (hitvec[w]) hit_idx = WPTR_W'(w);
  end

  assign hit       = |hitvec;
  assign victim    = rr[set_w[0]];
  assign base_line = (state == ST_FILL) ? mem_rdata : w_line[hit_idx];
  assign rd_word   = base_line[woff_q*DATA_W +: DATA_W];

  always_comb begin
    new_line = base_line;
    if (wr_q) new_line[woff_q*DATA_W +: DATA_W] = wd_q;
  end

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      key_q      <= '0;
      sweep_cnt  <= '0;
      vic_q      <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rekey) begin
            key_q     <= key_in;
            sweep_cnt <= '0;
            state     <= ST_SWEEP;
          end else if (accept) begin
            state <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_rdata <= wr_q ? wd_q : rd_word;
            state      <= ST_IDLE;
          end else begin
            vic_q <= victim;
            state <= (w_valid[victim] && w_dirty[victim]) ? ST_WB : ST_FILL;
          end
        end
        ST_WB: if (mem_ack) state <= ST_FILL;
        ST_FILL: begin
          if (mem_ack) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_rdata <= wr_q ? wd_q : rd_word;
            state      <= ST_IDLE;
          end
        end
        default: begin
          sweep_cnt <= sweep_cnt + 1'b1;
          if (sweep_cnt == IDX_W'(SETS - 1)) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      la_q   <= req_addr[ADDR_W-1:OFF_W];
      woff_q <= req_addr[OFF_W-1:BOFF_W];
      wr_q   <= req_write;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
    end else if (state == ST_FILL && mem_ack) begin
      rr[set_w[0]] <= (rr[set_w[0]] == WPTR_W'(WAYS - 1)) ? '0 : rr[set_w[0]] + 1'b1;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_WB) || (state == ST_FILL);
  assign mem_write = (state == ST_WB);
  assign mem_addr  = (state == ST_WB) ? w_tag[vic_q] : la_q;
  assign mem_wdata = w_line[vic_q];

  // R3: the full-address compare never matches in two ways
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK) |-> $onehot0(hitvec))
    else $error("more than one way hit");

  // R4: a lookup hit is answered on the next cycle
  assert_hit_answer_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && hit) |=> (resp_valid && resp_hit))
    else $error("hit not answered");

  // R5: responses only follow a lookup or a refill
  assert_resp_origin_R5: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(state) == ST_LOOK || $past(state) == ST_FILL))
    else $error("stray response");

  // R6: an acknowledged write-back is followed by the refill read
  assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_write && mem_ack) |=> (mem_req && !mem_write))
    else $error("refill did not follow write-back");

  // R8: a key load closes the request port
  assert_rekey_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (req_ready && key_load) |=> !req_ready)
    else $error("request port open after key load");

endmodule

// File: tb/keyed_rand_cache_test.sv
`timescale 1ns/1ps
module keyed_rand_cache_test;

  localparam bit SKEW = 1'b0;
  localparam bit [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                   4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_load = 1'b0;
  logic [31:0] key_in = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic mem_req, mem_write;
  logic [25:0] mem_addr;
  logic [511:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [511:0] mem_rdata = '0;

  always #2 clk = ~clk;

  keyed_rand_cache #(.SKEW(SKEW)) uut (
    .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // ---------------- next-level memory responder ----------------
  logic [511:0] mstore [logic [25:0]];
  int wb_cnt = 0;
  logic [25:0] wb_addr;
  logic [511:0] wb_line;

  function automatic logic [511:0] get_mem(input logic [25:0] la);
    logic [511:0] l;
    if (mstore.exists(la)) return mstore[la];
    for (int i = 0; i < 16; i++) l[32*i +: 32] = (32'(la) * 32'd16 + 32'(i)) ^ 32'hA500_0000;
    return l;
  endfunction

  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        dly = 0;
      end else if (mem_req) begin
        dly++;
        if (dly == 2) begin
          dly = 0;
          mem_ack = 1'b1;
          if (mem_write) begin
            mstore[mem_addr] = mem_wdata;
            wb_cnt++;
            wb_addr = mem_addr;
            wb_line = mem_wdata;
          end else begin
            mem_rdata = get_mem(mem_addr);
          end
        end
      end
    end
  end

  // ---------------- reference model ----------------
  logic [31:0]  key_m = '0;
  bit           bvalid [4][16];
  bit           bdirty [4][16];
  logic [25:0]  btag   [4][16];
  logic [511:0] bdata  [4][16];
  int           brr    [16];

  function automatic logic [31:0] bsub(input logic [31:0] x);
    logic [31:0] o;
    for (int i = 0; i < 8; i++) o[4*i +: 4] = SB[x[4*i +: 4]];
    return o;
  endfunction

  // R2 set index, written from the requirement
  function automatic logic [3:0] bidx(input logic [25:0] la, input logic [31:0] k, input int w);
    logic [31:0] x, y, z;
    logic [3:0] r;
    x = {6'd0, la} ^ k ^ (SKEW ? 32'(w) * 32'h9E3779B9 : 32'd0);
    y = bsub(x);
    y = y ^ {y[18:0], y[31:19]};
    z = bsub(y);
    r = '0;
    for (int i = 0; i < 8; i++) r = r ^ z[4*i +: 4];
    return r;
  endfunction

  task automatic access(input bit wr, input logic [25:0] la, input int wo, input logic [31:0] d);
    int s [4];
    int hw, v, n, wb0;
    bit exp_wb;
    logic [25:0] exp_wb_addr;
    logic [511:0] exp_wb_line, line;
    logic [31:0] exp_rd;
    hw = -1;
    for (int w = 0; w < 4; w++) begin
      s[w] = int'(bidx(la, key_m, w));
      if (bvalid[w][s[w]] && btag[w][s[w]] == la) hw = w;
    end
    v = brr[s[0]];
    exp_wb = (hw < 0) && bvalid[v][s[v]] && bdirty[v][s[v]];
    exp_wb_addr = btag[v][s[v]];
    exp_wb_line = bdata[v][s[v]];
    line = (hw >= 0) ? bdata[hw][s[hw]] : get_mem(la);
    if (wr) line[32*wo +: 32] = d;
    exp_rd = line[32*wo +: 32];

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {la, 4'(wo), 2'b00}; req_wdata = d;
    wb0 = wb_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!resp_valid, $sformatf("R4 resp early for %h: got %0b exp 0", la, resp_valid));
    if (hw >= 0) begin
      @(negedge clk);
      chk(resp_valid && resp_hit && resp_rdata == exp_rd,
          $sformatf("R4 hit %h: got v%0b h%0b %h exp v1 h1 %h", la, resp_valid, resp_hit, resp_rdata, exp_rd));
      bdata[hw][s[hw]] = line;
      if (wr) bdirty[hw][s[hw]] = 1'b1;
    end else begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!resp_valid && n < 50);
      chk(resp_valid && !resp_hit && resp_rdata == exp_rd,
          $sformatf("R5 miss %h: got v%0b h%0b %h exp v1 h0 %h", la, resp_valid, resp_hit, resp_rdata, exp_rd));
      chk((wb_cnt - wb0) == int'(exp_wb),
          $sformatf("R6 write-back count for %h: got %0d exp %0d", la, wb_cnt - wb0, exp_wb));
      if (exp_wb)
        chk(wb_addr == exp_wb_addr && wb_line == exp_wb_line,
            $sformatf("R6 write-back line: got %h exp %h", wb_addr, exp_wb_addr));
      bvalid[v][s[v]] = 1'b1;
      bdirty[v][s[v]] = wr;
      btag[v][s[v]]   = la;
      bdata[v][s[v]]  = line;
      brr[s[0]] = (brr[s[0]] + 1) % 4;
    end
    chk(req_ready, $sformatf("R4 ready after answer: got %0b exp 1", req_ready));
  endtask

  task automatic rekey(input logic [31:0] k);
    int n;
    @(negedge clk);
    key_load = 1'b1; key_in = k;
    @(negedge clk);
    key_load = 1'b0;
    n = 0;
    while (!req_ready && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 16, $sformatf("R8 sweep length: got %0d exp 16", n));
    key_m = k;
    for (int w = 0; w < 4; w++)
      for (int st = 0; st < 16; st++) bvalid[w][st] = 1'b0;
  endtask

  function automatic logic [25:0] next_same(input logic [25:0] from, input logic [3:0] st);
    logic [25:0] a;
    a = from + 1'b1;
    while (bidx(a, key_m, 0) != st) a = a + 1'b1;
    return a;
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [25:0] a, b [5], c;
    logic [31:0] lf;
    for (int w = 0; w < 4; w++)
      for (int st = 0; st < 16; st++) begin
        bvalid[w][st] = 1'b0; bdirty[w][st] = 1'b0; btag[w][st] = '0; bdata[w][st] = '0;
      end
    for (int st = 0; st < 16; st++) brr[st] = 0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req,
        $sformatf("R1 reset outputs: got r%0b v%0b m%0b exp r1 v0 m0", req_ready, resp_valid, mem_req));

    a = 26'h0012345;
    access(1'b0, a, 5, '0);             // R1 first access misses, R5 refill
    access(1'b0, a, 9, '0);             // R4 hit
    access(1'b1, a, 3, 32'hDEAD_0003);  // R9 write hit
    access(1'b0, a, 3, '0);             // R9 read back

    // R7 / R6 / R2: four more lines that share a's set
    b[0] = a;
    for (int i = 1; i < 5; i++) b[i] = next_same(b[i-1], bidx(a, key_m, 0));
    for (int i = 1; i < 5; i++) access(1'b0, b[i], i, '0);  // 4th one evicts dirty a
    access(1'b0, a, 3, '0);             // R7 a returns, evicts clean b1 without write
    access(1'b0, b[2], 0, '0);          // R3 colliding residents hit
    access(1'b0, b[3], 1, '0);
    access(1'b0, b[1], 2, '0);          // R7 evicts next in order

    c = 26'h0300000;
    access(1'b1, c, 15, 32'h1234_5678); // R9 write miss allocates dirty
    access(1'b0, c, 15, '0);

    rekey(32'h5A17_C3E9);               // R8
    access(1'b0, b[2], 0, '0);          // R8 old line now misses
    access(1'b0, c, 15, '0);            // R8 dirty data dropped, memory copy returned

    // R2 conflict set under the new key with dirty lines
    b[0] = 26'h0040000;
    for (int i = 1; i < 5; i++) b[i] = next_same(b[i-1], bidx(b[0], key_m, 0));
    for (int i = 0; i < 5; i++) access(1'b1, b[i], i, 32'hB000_0000 + 32'(i));
    access(1'b0, b[0], 0, '0);

    // mixed traffic against the model
    lf = 32'hACE1_1234;
    for (int it = 0; it < 250; it++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      access(lf[5], 26'h0000100 + 26'(lf[10:6] % 5'd24) * 26'd37, int'(lf[14:11]), lf);
      if (it == 120) rekey(lf ^ 32'h0F0F_0F0F);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule